// File: doc/BRIEF.md
# Serial register-access control-frame sequencer

This block sits on the controller side of a serial position-encoder link. It carries a single register read or write to the encoder as a control frame, one bit at a time, inside the stream of ordinary position-data frames. Once per outer frame, marked by a one-clock strobe from the position-frame timing engine, it puts one control bit on `cdm_out` and takes one response bit from `cds_in`. A complete transfer therefore spans many outer frames, and position data keeps flowing the whole time.

The user places a request while `busy` is low: the direction, a 3-bit slave ID, a 7-bit register address and, for a write, an 8-bit data byte. The block first makes sure enough all-zero control bits have gone out since the last transfer. It then sends the frame: start, select, ID, address, a 4-bit check code, the direction code, the data field and its check code, and a stop bit. At the end it pulses `done` and presents read data and an error flag. Command frames, slave requests for extra time and transfers of several registers in a row are not handled.

Bit positions inside the frame, counted from the start bit as position 0, are: 0 start, 1 select, 2-4 ID, 5-11 address, 12-15 header check, 16-18 direction code, 19-26 data, 27-30 data check, 31 stop.

Top module: `ctl_frame_seq`

## Requirements
- R1: `cdm_out` changes only on the clock edge where `frame_stb` is high, so each outer frame carries exactly one control bit. The `cds_in` value sampled on a strobe edge is the slave's answer to the bit that `cdm_out` held during that frame.
- R2: The start bit is sent only after at least IDLE_MIN (default 14) consecutive frames with `cdm_out` low. Frames counted while idle before a request count toward this. The count restarts from zero after each stop bit.
- R3: The frame opens with start = 1 and select = 1, followed by the slave ID (3 bits) and then the register address (7 bits), both most significant bit first.
- R4: The check code is a 4-bit CRC with polynomial x^4+x+1, initial value 0, fed most significant bit first. It is transmitted bit-inverted, MSB first. The header check covers the 10 bits of ID followed by address. The write-data check covers the 8 data bits.
- R5: Positions 16-18 carry 011 for a write and 101 for a read.
- R6: For a write, positions 19-26 carry the data byte MSB first and positions 27-30 carry its inverted check code. For a read, all 12 of these positions are 0.
- R7: Position 31 (stop) is 0, and `cdm_out` stays 0 afterwards. `busy` falls and `done` is high for exactly one clock, in the clock after the strobe edge that ends the stop frame.
- R8: A request is taken only while `busy` is low, and `busy` rises on the next clock. A request raised while `busy` is high is ignored and does not alter the frame in progress.
- R9: A 0 on `cds_in` answering position 18 (the slave's start position in the direction field) is a request for extra time. It is not supported: it sets `error`, and the frame still runs to its stop bit.
- R10: On a read, the slave's bits at positions 19-26 form `rdata`, MSB first, and its bits at 27-30 must equal the inverted CRC of that byte, or `error` is set. `rdata` is updated when a read ends and is held otherwise. `error` is cleared when a request is taken and otherwise held.
- R11: A synchronous active-high `rst` returns the block to idle with `cdm_out`, `busy`, `done`, `error` and `rdata` low and the idle-frame count cleared, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_id | input | 3 | Slave ID |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| frame_stb | input | 1 | One-clock pulse at the end of each outer position frame |
| cds_in | input | 1 | Slave response bit for the current frame |
| cdm_out | output | 1 | Control bit for the current frame |
| busy | output | 1 | A request is pending or in flight |
| done | output | 1 | One-clock pulse after the stop bit |
| error | output | 1 | Extra-time request or read check failure on the last transfer |
| rdata | output | 8 | Data returned by the last read |

## Verification
Two pairs of events can fall on the same clock. A request can be taken on an edge that also carries a frame strobe, and a fresh request can arrive in the very clock where `done` is high. The bench lines up the first pair by watching its own strobe-phase counter, and the second by raising `req_valid` as soon as it sees `done`. A behavioural reference model, updated on every edge, judges both cases: a request taken on a strobe edge must not start the frame on that same edge, and a request in the `done` clock must be taken at once while the returned `error` and `rdata` still match the transfer that just ended.

// File: rtl/ctl_frame_seq.sv
module ctl_frame_seq #(
  parameter int IDLE_MIN = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [2:0] req_id,
  input  logic [6:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       frame_stb,
  input  logic       cds_in,
  output logic       cdm_out,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [7:0] rdata
);

  localparam int CW = $clog2(IDLE_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(IDLE_MIN);
  localparam logic [4:0] P_ACK = 5'd18;
  localparam logic [4:0] P_DAT = 5'd19;
  localparam logic [4:0] P_END = 5'd31;

  function automatic logic [3:0] crc4(input logic [9:0] d);
    logic [3:0] c;
    logic fb;
    c = 4'h0;
    for (int i = 9; i >= 0; i--) begin
      fb = c[3] ^ d[i];
      c  = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    end
    return c;
  endfunction

  logic          infr, wr;
  logic [4:0]    pos;
  logic [CW-1:0] cnt;
  logic [31:0]   tx;
  logic [11:0]   rx;

  wire [CW-1:0] cnt_n = (cnt == CMAX) ? cnt : cnt + 1'b1;
  wire          rx_bad = (~crc4({2'b00, rx[11:4]})) != rx[3:0];

  assign cdm_out = infr & tx[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; infr <= 1'b0; done <= 1'b0; error <= 1'b0; wr <= 1'b0;
      cnt <= '0; pos <= '0; tx <= '0; rx <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && req_valid) begin
        busy  <= 1'b1;
        error <= 1'b0;
        wr    <= req_write;
        tx    <= {2'b11, req_id, req_addr, ~crc4({req_id, req_addr}),
                  req_write ? 3'b011 : 3'b101,
                  req_write ? req_wdata : 8'h00,
                  req_write ? ~crc4({2'b00, req_wdata}) : 4'h0, 1'b0};
      end
      if (frame_stb) begin
        if (!infr) begin
          cnt <= cnt_n;
          if (busy && cnt_n == CMAX) begin
            infr <= 1'b1;
            pos  <= '0;
          end
        end else begin
          tx  <= {tx[30:0], 1'b0};
          pos <= pos + 1'b1;
          if (pos >= P_DAT && pos < P_END) rx <= {rx[10:0], cds_in};
          if (pos == P_ACK && !cds_in) error <= 1'b1;
          if (pos == P_END) begin
            infr <= 1'b0;
            busy <= 1'b0;
            done <= 1'b1;
            cnt  <= '0;
            if (!wr) begin
              rdata <= rx[11:4];
              if (rx_bad) error <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r1_cdm_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_stb) && !$past(rst)) |-> $stable(cdm_out));

  a_r2_preamble_met: assert property (@(posedge clk) disable iff (rst)
    $rose(infr) |-> ($past(cnt) >= CMAX - 1'b1));

  a_r3_start_bit_high: assert property (@(posedge clk) disable iff (rst)
    $rose(infr) |-> cdm_out);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !cdm_out));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cdm_out);

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(rst) && $past(busy)) |-> $stable(rdata));

endmodule

// File: tb/sim_ctl_frame_seq.sv
module sim_ctl_frame_seq;
  localparam int IDLE = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, req_valid = 1'b0, req_write = 1'b0, frame_stb = 1'b0, cds_in = 1'b0;
  logic [2:0] req_id = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic cdm_out, busy, done, error;
  logic [7:0] rdata;

  ctl_frame_seq #(.IDLE_MIN(IDLE)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .frame_stb(frame_stb), .cds_in(cds_in), .cdm_out(cdm_out),
    .busy(busy), .done(done), .error(error), .rdata(rdata));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input int n, input logic [15:0] v);
    logic [3:0] r = 4'h0;
    for (int k = n - 1; k >= 0; k--) begin
      bit b = r[3] ^ v[k];
      r = {r[2:0], 1'b0};
      if (b) r = r ^ 4'b0011;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_frame(input bit w, input logic [2:0] id,
                                            input logic [6:0] a, input logic [7:0] d);
    logic [31:0] f = '0;
    int p = 31;
    logic [3:0] h = ~ref_crc(10, {6'b0, id, a});
    logic [3:0] dc = ~ref_crc(8, {8'b0, d});
    f[p--] = 1'b1; f[p--] = 1'b1;
    for (int k = 2; k >= 0; k--) f[p--] = id[k];
    for (int k = 6; k >= 0; k--) f[p--] = a[k];
    for (int k = 3; k >= 0; k--) f[p--] = h[k];
    f[p--] = !w; f[p--] = w; f[p--] = 1'b1;
    for (int k = 7; k >= 0; k--) f[p--] = w ? d[k] : 1'b0;
    for (int k = 3; k >= 0; k--) f[p--] = w ? dc[k] : 1'b0;
    f[p] = 1'b0;
    return f;
  endfunction

  // strobe generator
  int gap = 3, gcnt = 0;
  always @(negedge clk) begin
    frame_stb <= (gcnt == 0);
    gcnt <= (gcnt >= gap - 1) ? 0 : gcnt + 1;
  end

  // reference model
  bit m_busy, m_inf, m_done, m_err, m_wr;
  int m_pos, m_cnt;
  logic [31:0] m_bits;
  logic [11:0] m_rx;
  logic [7:0] m_rdata;
  always @(posedge clk) begin : mdl
    bit wb;
    if (rst) begin
      m_busy = 0; m_inf = 0; m_done = 0; m_err = 0; m_cnt = 0; m_pos = 0; m_rdata = 0; m_rx = 0;
    end else begin
      wb = m_busy;
      m_done = 0;
      if (!wb && req_valid) begin
        m_busy = 1; m_err = 0; m_wr = req_write;
        m_bits = ref_frame(req_write, req_id, req_addr, req_wdata);
      end
      if (frame_stb) begin
        if (!m_inf) begin
          if (m_cnt < IDLE) m_cnt++;
          if (wb && m_cnt >= IDLE) begin m_inf = 1; m_pos = 0; end
        end else begin
          if (m_pos == 18 && !cds_in) m_err = 1;
          if (m_pos >= 19 && m_pos <= 30) m_rx = {m_rx[10:0], cds_in};
          if (m_pos == 31) begin
            m_inf = 0; m_busy = 0; m_done = 1; m_cnt = 0;
            if (!m_wr) begin
              m_rdata = m_rx[11:4];
              if (~ref_crc(8, {8'b0, m_rx[11:4]}) != m_rx[3:0]) m_err = 1;
            end
          end else m_pos++;
        end
      end
    end
  end

  // slave response
  bit stall = 0;
  logic [7:0] sdata = '0;
  logic [3:0] scrc = '0;
  always @(negedge clk) begin
    if (!m_inf) cds_in = 1'b0;
    else if (m_pos == 18) cds_in = !stall;
    else if (!m_wr && m_pos >= 19 && m_pos <= 26) cds_in = sdata[26 - m_pos];
    else if (!m_wr && m_pos >= 27 && m_pos <= 30) cds_in = scrc[30 - m_pos];
    else cds_in = 1'b0;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic e_cdm;
      e_cdm = m_inf ? m_bits[31 - m_pos] : 1'b0;
      chk(cdm_out === e_cdm, "R1 R3 R4 R5 R6 cdm_out", {31'b0, cdm_out}, {31'b0, e_cdm});
      chk(busy === m_busy, "R8 busy", {31'b0, busy}, {31'b0, m_busy});
      chk(done === m_done, "R7 done", {31'b0, done}, {31'b0, m_done});
      chk(error === m_err, "R9 R10 error", {31'b0, error}, {31'b0, m_err});
      chk(rdata === m_rdata, "R10 rdata", {24'b0, rdata}, {24'b0, m_rdata});
    end
  end

  // frame monitor
  logic cdm_q = 1'b0;
  int zrun = 0, cap_n = 0;
  bit cap_on = 0;
  logic [31:0] cap = '0;
  always @(negedge clk) begin
    if (rst) begin
      zrun = 0; cap_on = 0;
    end else if (frame_stb) begin
      if (!cap_on) begin
        if (cdm_q) begin
          chk(zrun >= IDLE, "R2 idle frames before start", zrun, IDLE);
          cap_on = 1; cap_n = 1; cap = 32'h1;
        end else zrun++;
      end else begin
        cap = {cap[30:0], cdm_q};
        cap_n++;
        if (cap_n == 32) begin cap_on = 0; zrun = 0; end
      end
    end
    cdm_q = cdm_out;
  end

  task automatic set_read(input logic [7:0] d, input bit bad);
    sdata = d;
    scrc = ~ref_crc(8, {8'b0, d}) ^ (bad ? 4'b0100 : 4'b0000);
  endtask

  task automatic do_req(input bit w, input logic [2:0] id, input logic [6:0] a,
                        input logic [7:0] d, input bit inject);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_write = w; req_id = id; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      while (!(m_inf && m_pos == 9)) @(negedge clk);
      req_write = !w; req_id = ~id; req_addr = ~a; req_valid = 1'b1;   // R8: must be ignored
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(cap === ref_frame(w, id, a, d), "R3 R4 R5 R6 R7 R8 captured frame", cap, ref_frame(w, id, a, d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cdm_out, busy, done, error, rdata} === 12'h0, "R11 reset state", {20'b0, cdm_out, busy, done, error, rdata}, 0);
    rst = 1'b0;

    do_req(1, 3'd5, 7'h2A, 8'hC3, 0);
    chk(error === 1'b0, "R9 clean write no error", error, 0);

    set_read(8'h5A, 0);
    do_req(0, 3'd2, 7'h11, 8'h00, 0);
    chk(rdata === 8'h5A, "R10 read data", rdata, 8'h5A);
    chk(error === 1'b0, "R10 good check code", error, 0);

    set_read(8'h3C, 1);
    do_req(0, 3'd4, 7'h60, 8'h00, 0);
    chk(error === 1'b1, "R10 bad check code flagged", error, 1);
    chk(rdata === 8'h3C, "R10 data despite bad check", rdata, 8'h3C);

    stall = 1;
    do_req(1, 3'd1, 7'h03, 8'h99, 0);
    chk(error === 1'b1, "R9 extra-time request flagged", error, 1);
    chk(rdata === 8'h3C, "R10 rdata held over write", rdata, 8'h3C);
    stall = 0;

    gap = 1;
    do_req(1, 3'd7, 7'h7F, 8'hFF, 0);
    set_read(8'h81, 0);
    do_req(0, 3'd0, 7'h00, 8'h00, 0);
    chk(rdata === 8'h81, "R1 R10 read at full strobe rate", rdata, 8'h81);

    gap = 3;
    do_req(1, 3'd6, 7'h05, 8'h11, 1);

    // request in the done clock
    set_read(8'hE7, 0);
    req_write = 0; req_id = 3'd3; req_addr = 7'h40; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    req_write = 1; req_id = 3'd2; req_addr = 7'h22; req_wdata = 8'h0F; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R8 request in done clock taken", busy, 1);
    chk(rdata === 8'hE7, "R10 rdata after done", rdata, 8'hE7);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(cap === ref_frame(1, 3'd2, 7'h22, 8'h0F), "R7 R8 frame after done-clock request", cap, ref_frame(1, 3'd2, 7'h22, 8'h0F));

    // request coincident with a strobe
    @(negedge clk);
    while (gcnt != 0) @(negedge clk);
    set_read(8'h42, 0);
    req_write = 0; req_id = 3'd5; req_addr = 7'h0C; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(rdata === 8'h42, "R2 R10 read after strobe-coincident request", rdata, 8'h42);

    // reset mid-frame
    req_write = 1; req_id = 3'd1; req_addr = 7'h55; req_wdata = 8'hAA; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(m_inf && m_pos == 10)) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({cdm_out, busy, done, error, rdata} === 12'h0, "R11 mid-frame reset", {20'b0, cdm_out, busy, done, error, rdata}, 0);
    rst = 1'b0;
    set_read(8'h17, 0);
    do_req(0, 3'd6, 7'h31, 8'h00, 0);
    chk(rdata === 8'h17, "R2 R11 read after reset", rdata, 8'h17);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule